// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block picks where each of the two ALU operands of the instruction in the execute stage comes from. Without forwarding, an operand is taken from the register-file read value captured at decode. When an older instruction still in the pipeline is about to write that same register, the value in the register file is stale. The block then routes the newer value around the register file instead.

Two older instructions can supply a value. The first is the instruction one slot ahead, whose ALU result sits in the execute/memory pipeline register. The second is the instruction two slots ahead, whose write-back data sits in the memory/write-back pipeline register. When both write the register an operand needs, the nearer one holds the current value and is chosen. Register index zero is a constant register, so a write aimed at it is never forwarded.

The unit is purely combinational, with no clock and no state. It reports the source choice for each operand as a 2-bit select code and also drives the two chosen operand values. A dependency three instructions back is outside this block: a register file that passes a same-cycle write through to its read ports resolves it during decode.

Top module: `fwd_unit`

## Requirements
- R1: Operand A select is 2'b10 and operand A equals the execute/memory ALU result when that stage writes (enable 1), its destination is nonzero and equals the operand A source index.
- R2: Operand B select is 2'b10 and operand B equals the execute/memory ALU result under the R1 conditions, compared against the operand B source index.
- R3: Operand A select is 2'b01 and operand A equals the write-back data when only the memory/write-back stage writes a nonzero destination equal to the operand A source index.
- R4: Operand B select is 2'b01 and operand B equals the write-back data under the R3 conditions, compared against the operand B source index.
- R5: When both older stages match one operand, the execute/memory stage wins: the select is 2'b10 and the ALU result is used.
- R6: A destination index of zero never causes forwarding, even with its write enable set.
- R7: A stage whose write enable is 0 never causes forwarding, even if its destination matches.
- R8: With no match, the select is 2'b00 and the operand equals its register-file read value.
- R9: The select code 2'b11 is never produced, and each operand always equals the source that its select names.
- R10: The two operands are resolved independently: in one cycle each may forward from a different stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | AW | Register index of operand A of the executing instruction |
| src_b_idx | input | AW | Register index of operand B of the executing instruction |
| exm_dst | input | AW | Destination index held in the execute/memory register |
| exm_wr | input | 1 | Write enable of the execute/memory instruction |
| mwb_dst | input | AW | Destination index held in the memory/write-back register |
| mwb_wr | input | 1 | Write enable of the memory/write-back instruction |
| rf_a | input | DW | Register-file value for operand A |
| rf_b | input | DW | Register-file value for operand B |
| exm_result | input | DW | ALU result in the execute/memory register |
| mwb_data | input | DW | Write-back data in the memory/write-back register |
| fwd_a_sel | output | 2 | Source code for operand A (00 file, 01 write-back, 10 ALU result) |
| fwd_b_sel | output | 2 | Source code for operand B, same encoding |
| opnd_a | output | DW | Chosen operand A |
| opnd_b | output | DW | Chosen operand B |

## Verification
Two hits on the same operand can occur in the same cycle, one from each older stage: the bench drives both destinations equal to one source index with both enables set and expects the execute/memory source. The same test is repeated with that stage's destination at zero or its enable low, where the write-back source must then be chosen. Operand A and operand B can also forward in the same cycle from different stages. A pseudo-random sweep over a small index range makes these collisions frequent, and an independent model computes the expected select and operand for each vector.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
   typedef enum logic [1:0] {
      SEL_RF   = 2'b00,
      SEL_WB   = 2'b01,
      SEL_EXM  = 2'b10,
      SEL_RSVD = 2'b11
   } fwd_sel_e;

   localparam int unsigned NUM_OPND = 2;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
   parameter int unsigned AW         = 5,
   parameter bit          GUARD_ZERO = 1'b1
) (
   input  logic [AW-1:0] src_idx,
   input  logic [AW-1:0] dst_idx,
   input  logic          dst_wr,
   output logic          hit
);
   logic idx_eq;
   logic dst_live;

   assign idx_eq = (src_idx == dst_idx);

   generate
      if (GUARD_ZERO) begin : g_guard
         assign dst_live = dst_wr && (dst_idx != '0);
      end else begin : g_noguard
         assign dst_live = dst_wr;
      end
   endgenerate

   assign hit = dst_live && idx_eq;
endmodule

// File: rtl/fwd_select.sv
module fwd_select
   import fwd_pkg::*;
(
   input  logic     hit_exm,
   input  logic     hit_wb,
   output fwd_sel_e sel
);
   always_comb begin
      if (hit_exm)     sel = SEL_EXM;
      else if (hit_wb) sel = SEL_WB;
      else             sel = SEL_RF;
   end
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
   import fwd_pkg::*;
#(
   parameter int unsigned DW = 32
) (
   input  fwd_sel_e      sel,
   input  logic [DW-1:0] rf_val,
   input  logic [DW-1:0] exm_val,
   input  logic [DW-1:0] wb_val,
   output logic [DW-1:0] out_val
);
   always_comb begin
      unique case (sel)
         SEL_EXM: out_val = exm_val;
         SEL_WB:  out_val = wb_val;
         default: out_val = rf_val;
      endcase
   end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int unsigned AW         = 5,
   parameter int unsigned DW         = 32,
   parameter bit          GUARD_ZERO = 1'b1
) (
   input  logic [AW-1:0] src_a_idx,
   input  logic [AW-1:0] src_b_idx,
   input  logic [AW-1:0] exm_dst,
   input  logic          exm_wr,
   input  logic [AW-1:0] mwb_dst,
   input  logic          mwb_wr,
   input  logic [DW-1:0] rf_a,
   input  logic [DW-1:0] rf_b,
   input  logic [DW-1:0] exm_result,
   input  logic [DW-1:0] mwb_data,
   output logic [1:0]    fwd_a_sel,
   output logic [1:0]    fwd_b_sel,
   output logic [DW-1:0] opnd_a,
   output logic [DW-1:0] opnd_b
);
   localparam int unsigned NREGS = 1 << AW;

   initial begin
      assert (AW >= 1 && AW <= 8)
         else $error("fwd_unit: AW %0d out of range", AW);
      assert (DW >= 1)
         else $error("fwd_unit: DW must be positive");
      assert (NREGS >= 2)
         else $error("fwd_unit: register space too small");
   end

   logic [AW-1:0] src_idx [NUM_OPND];
   logic [DW-1:0] rf_val  [NUM_OPND];
   logic [DW-1:0] out_val [NUM_OPND];
   fwd_sel_e      sel_v   [NUM_OPND];

   assign src_idx[0] = src_a_idx;
   assign src_idx[1] = src_b_idx;
   assign rf_val[0]  = rf_a;
   assign rf_val[1]  = rf_b;

   generate
      for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
         logic hit_exm;
         logic hit_wb;

         fwd_match #(.AW(AW), .GUARD_ZERO(GUARD_ZERO)) u_m_exm (
            .src_idx (src_idx[g]),
            .dst_idx (exm_dst),
            .dst_wr  (exm_wr),
            .hit     (hit_exm)
         );

         fwd_match #(.AW(AW), .GUARD_ZERO(GUARD_ZERO)) u_m_wb (
            .src_idx (src_idx[g]),
            .dst_idx (mwb_dst),
            .dst_wr  (mwb_wr),
            .hit     (hit_wb)
         );

         fwd_select u_sel (
            .hit_exm (hit_exm),
            .hit_wb  (hit_wb),
            .sel     (sel_v[g])
         );

         fwd_opmux #(.DW(DW)) u_mux (
            .sel     (sel_v[g]),
            .rf_val  (rf_val[g]),
            .exm_val (exm_result),
            .wb_val  (mwb_data),
            .out_val (out_val[g])
         );
      end
   endgenerate

   assign fwd_a_sel = sel_v[0];
   assign fwd_b_sel = sel_v[1];
   assign opnd_a    = out_val[0];
   assign opnd_b    = out_val[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
   parameter int unsigned AW = 5,
   parameter int unsigned DW = 32
) (
   input logic [AW-1:0] src_a_idx,
   input logic [AW-1:0] src_b_idx,
   input logic [AW-1:0] exm_dst,
   input logic          exm_wr,
   input logic [AW-1:0] mwb_dst,
   input logic          mwb_wr,
   input logic [DW-1:0] rf_a,
   input logic [DW-1:0] rf_b,
   input logic [DW-1:0] exm_result,
   input logic [DW-1:0] mwb_data,
   input logic [1:0]    fwd_a_sel,
   input logic [1:0]    fwd_b_sel,
   input logic [DW-1:0] opnd_a,
   input logic [DW-1:0] opnd_b
);
   always_comb begin
      a_r9_sel_legal: assert (fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11)
         else $error("reserved select code driven");
      a_r9_opnd_a_tracks: assert (opnd_a == (fwd_a_sel == 2'b10 ? exm_result :
                                              fwd_a_sel == 2'b01 ? mwb_data : rf_a))
         else $error("operand A disagrees with its select");
      a_r9_opnd_b_tracks: assert (opnd_b == (fwd_b_sel == 2'b10 ? exm_result :
                                              fwd_b_sel == 2'b01 ? mwb_data : rf_b))
         else $error("operand B disagrees with its select");
      a_r6_zero_dst_quiet: assert (!(exm_dst == '0 && mwb_dst == '0) ||
                                   (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00))
         else $error("forwarded from register zero");
      a_r7_no_wr_quiet: assert (exm_wr || mwb_wr ||
                                (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00))
         else $error("forwarded with no writer");
      a_r5_newer_wins: assert (!(exm_wr && exm_dst != '0 && exm_dst == src_a_idx) ||
                               fwd_a_sel == 2'b10)
         else $error("older stage beat newer on A");
      a_r8_rf_when_idle: assert (fwd_b_sel != 2'b00 || opnd_b == rf_b)
         else $error("operand B not from file on select 00");
   end
endmodule

bind fwd_unit fwd_unit_chk #(.AW(AW), .DW(DW)) u_chk (
   .src_a_idx  (src_a_idx),
   .src_b_idx  (src_b_idx),
   .exm_dst    (exm_dst),
   .exm_wr     (exm_wr),
   .mwb_dst    (mwb_dst),
   .mwb_wr     (mwb_wr),
   .rf_a       (rf_a),
   .rf_b       (rf_b),
   .exm_result (exm_result),
   .mwb_data   (mwb_data),
   .fwd_a_sel  (fwd_a_sel),
   .fwd_b_sel  (fwd_b_sel),
   .opnd_a     (opnd_a),
   .opnd_b     (opnd_b)
);

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;
   localparam int unsigned AW = 5;
   localparam int unsigned DW = 32;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic [AW-1:0] src_a_idx, src_b_idx, exm_dst, mwb_dst;
   logic          exm_wr, mwb_wr;
   logic [DW-1:0] rf_a, rf_b, exm_result, mwb_data;
   logic [1:0]    fwd_a_sel, fwd_b_sel;
   logic [DW-1:0] opnd_a, opnd_b;

   fwd_unit #(.AW(AW), .DW(DW)) dut (
      .src_a_idx (src_a_idx), .src_b_idx (src_b_idx),
      .exm_dst (exm_dst), .exm_wr (exm_wr),
      .mwb_dst (mwb_dst), .mwb_wr (mwb_wr),
      .rf_a (rf_a), .rf_b (rf_b),
      .exm_result (exm_result), .mwb_data (mwb_data),
      .fwd_a_sel (fwd_a_sel), .fwd_b_sel (fwd_b_sel),
      .opnd_a (opnd_a), .opnd_b (opnd_b)
   );

   typedef struct {
      logic [1:0]    a_sel;
      logic [1:0]    b_sel;
      logic [DW-1:0] a_val;
      logic [DW-1:0] b_val;
      string         tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_run  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;

   function automatic logic [1:0] ref_sel(input logic [AW-1:0] s,
                                          input logic [AW-1:0] ed, input logic ew,
                                          input logic [AW-1:0] wd, input logic ww);
      if (ew && ed != 0 && ed == s) return 2'b10;
      if (ww && wd != 0 && wd == s) return 2'b01;
      return 2'b00;
   endfunction

   function automatic logic [DW-1:0] ref_val(input logic [1:0] sel, input logic [DW-1:0] rf);
      case (sel)
         2'b10:   return exm_result;
         2'b01:   return mwb_data;
         default: return rf;
      endcase
   endfunction

   task automatic drive(input logic [AW-1:0] sa, input logic [AW-1:0] sb,
                        input logic [AW-1:0] ed, input logic ew,
                        input logic [AW-1:0] wd, input logic ww,
                        input logic [DW-1:0] seed, input string tag);
      exp_t e;
      @(posedge clk);
      #1;
      src_a_idx = sa; src_b_idx = sb;
      exm_dst = ed; exm_wr = ew; mwb_dst = wd; mwb_wr = ww;
      rf_a = seed ^ 32'h1111_0001;
      rf_b = seed ^ 32'h2222_0002;
      exm_result = seed ^ 32'h4444_0004;
      mwb_data = seed ^ 32'h8888_0008;
      e.a_sel = ref_sel(sa, ed, ew, wd, ww);
      e.b_sel = ref_sel(sb, ed, ew, wd, ww);
      e.a_val = ref_val(e.a_sel, rf_a);
      e.b_val = ref_val(e.b_sel, rf_b);
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic report(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // monitor: compare on the falling edge, away from the driving edge
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            report(e.tag, "a_sel", {30'd0, fwd_a_sel}, {30'd0, e.a_sel});
            report(e.tag, "b_sel", {30'd0, fwd_b_sel}, {30'd0, e.b_sel});
            report(e.tag, "opnd_a", opnd_a, e.a_val);
            report(e.tag, "opnd_b", opnd_b, e.b_val);
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
         end
      end
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      src_a_idx = '0; src_b_idx = '0; exm_dst = '0; mwb_dst = '0;
      exm_wr = 1'b0; mwb_wr = 1'b0;
      rf_a = '0; rf_b = '0; exm_result = '0; mwb_data = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;

      drive(5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 32'h0000_0000, "R8_reset_idle");
      drive(5'd3, 5'd7, 5'd3, 1'b1, 5'd9, 1'b1, 32'h0101_0101, "R1_exm_a");
      drive(5'd4, 5'd6, 5'd6, 1'b1, 5'd2, 1'b1, 32'h0202_0202, "R2_exm_b");
      drive(5'd8, 5'd1, 5'd5, 1'b1, 5'd8, 1'b1, 32'h0303_0303, "R3_wb_a");
      drive(5'd2, 5'd11, 5'd12, 1'b1, 5'd11, 1'b1, 32'h0404_0404, "R4_wb_b");
      drive(5'd2, 5'd2, 5'd2, 1'b1, 5'd2, 1'b1, 32'h0505_0505, "R5_double_both");
      drive(5'd9, 5'd4, 5'd9, 1'b1, 5'd9, 1'b1, 32'h0606_0606, "R5_double_a");
      drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 32'h0707_0707, "R6_zero_dst");
      drive(5'd0, 5'd6, 5'd0, 1'b1, 5'd0, 1'b1, 32'h0808_0808, "R6_zero_src");
      drive(5'd7, 5'd7, 5'd0, 1'b1, 5'd7, 1'b1, 32'h0909_0909, "R6_exm_zero_wb_wins");
      drive(5'd13, 5'd13, 5'd13, 1'b0, 5'd13, 1'b0, 32'h0A0A_0A0A, "R7_no_enable");
      drive(5'd13, 5'd13, 5'd13, 1'b0, 5'd13, 1'b1, 32'h0B0B_0B0B, "R7_exm_off_wb_wins");
      drive(5'd14, 5'd15, 5'd16, 1'b1, 5'd17, 1'b1, 32'h0C0C_0C0C, "R8_no_match");
      drive(5'd20, 5'd21, 5'd20, 1'b1, 5'd21, 1'b1, 32'h0D0D_0D0D, "R10_split_sources");
      drive(5'd21, 5'd20, 5'd20, 1'b1, 5'd21, 1'b1, 32'h0E0E_0E0E, "R10_split_swapped");
      drive(5'd31, 5'd31, 5'd31, 1'b1, 5'd30, 1'b1, 32'hFFFF_FFFF, "R1_R2_top_index");

      for (int i = 0; i < 300; i++) begin
         logic [AW-1:0] sa, sb, ed, wd;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         sa = {3'd0, lfsr[1:0]};
         sb = {3'd0, lfsr[3:2]};
         ed = {3'd0, lfsr[5:4]};
         wd = {3'd0, lfsr[7:6]};
         drive(sa, sb, ed, lfsr[8], wd, lfsr[9], {lfsr, ~lfsr}, "R9_sweep");
      end

      @(posedge clk);
      @(posedge clk);
      n_run++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R9 scoreboard residue actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule